// File: doc/BRIEF.md
# NOR Flash Command Sequencer

This block models a parallel NOR flash device driven by the classic two-write unlock protocol. A host on a simple synchronous bus issues read strobes and write strobes with a word address. Bus writes are not stored directly. Instead, the sequencer decodes them as multi-cycle command sequences. A correct sequence programs one word, erases one sector or the whole array, switches reads to identification words, switches reads to the parameter query table, or enters a shortcut mode that skips the unlock pair.

Storage is an internal word array organised as `SECTORS` sectors of `SECTOR_BYTES` bytes. Programming can only clear bits. Erasing sets every word of the selected range to all ones, one word per clock, and raises `busy` for the whole fill. Reads return registered data one clock after the read strobe. The source of that data depends on the current mode: the array, the identification words, or the query table. Erase timing beyond the fill itself, status polling and toggle bits belong to a separate status block.

Top module: `nor_cmd_seq`

## Requirements
- R1: After reset `busy` is 0, `rdData` is 0 and the sequencer is in array-read mode; in that mode a read returns the array word at `addr` on the clock after the read strobe.
- R2: The sequence 0x00AA at unlock offset 0, 0x0055 at unlock offset 1, 0x00A0 at unlock offset 0 and then one data write programs the addressed word to the bitwise AND of its old value and the data. The next write after that returns to read mode.
- R3: The wrong data or the wrong command offset in any unlock or command cycle returns to read mode, so the remaining writes of the broken sequence leave the array unchanged. Command bytes other than 0x20, 0x80, 0x90 and 0xA0 in the command cycle also return to read mode.
- R4: A write whose low byte is 0xF0 returns to read mode from any state and leaves shortcut mode, except when a program is armed. In that case the write is programmed as data.
- R5: After 0x80, a second unlock pair, and 0x0030 written at any address, every word of the sector that holds that address becomes 0xFFFF. Other sectors are unchanged. `busy` is high for exactly words-per-sector clocks.
- R6: After 0x80, a second unlock pair, and 0x0010 written at unlock offset 0, every word becomes 0xFFFF and `busy` is high for exactly the total word count. The same 0x0010 written at any other offset starts no erase.
- R7: While an erase is running, every write is ignored. This includes complete program sequences and 0xF0.
- R8: 0x0020 in the command cycle enters shortcut mode. From then on each command cycle needs no unlock pair and may use any offset, and after a program the sequencer returns to the command cycle. Writing 0x0000 in identification mode leaves shortcut mode.
- R9: In identification mode (command 0x90), reads at sector offset 0 return `MANUF_ID`, offset 1 `DEVICE_ID`, offset 2 zero, and offsets 0x0E and 0x0F `EXT_ID0` and `EXT_ID1`. Every other offset reads the array.
- R10: Writing 0x0098 at command offset 0x55 from read mode or identification mode enters query mode. In query mode, reads at offset 0x10/0x11/0x12 return 0x0051/0x0052/0x0059, offset 0x27 returns log2 of the byte size, and offsets at or above `QRY_LEN` return 0. Any write in query mode returns to read mode.
- R11: The command offset is the word address modulo the words per sector, so unlock and command cycles are accepted in any sector.
- R12: An extra identification word that is configured as all ones is not returned; the array word at that offset is read instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rdEn | input | 1 | Read strobe; data appears on `rdData` after the next edge |
| wrEn | input | 1 | Write strobe; one command or data cycle per clock |
| addr | input | AW (10) | Word address: sector number above the sector offset |
| wrData | input | DW (16) | Write data; command codes sit in the low byte |
| rdData | output | DW (16) | Registered read data |
| busy | output | 1 | High while an erase fill is running |

## Verification
The bench uses the default build: four sectors of 256 sixteen-bit words, unlock offsets 0x55 and 0x2A, and `EXT_ID1` set to all ones. With four sectors, a sector erase can be checked at both of its boundaries against untouched neighbours. The whole array is also small enough that a full chip erase and its 1024-clock `busy` window fit in a short run. Because `EXT_ID1` is all ones, the fall-through of that identification offset to the array can be reached, and it is exercised next to a real extra ID at offset 0x0E.

// File: rtl/nor_seq_pkg.sv
`timescale 1ns/1ps
package nor_seq_pkg;
  localparam logic [7:0] C_UNL_A  = 8'hAA;
  localparam logic [7:0] C_UNL_B  = 8'h55;
  localparam logic [7:0] C_PROG   = 8'hA0;
  localparam logic [7:0] C_ESETUP = 8'h80;
  localparam logic [7:0] C_AUTO   = 8'h90;
  localparam logic [7:0] C_BYPASS = 8'h20;
  localparam logic [7:0] C_CHIP   = 8'h10;
  localparam logic [7:0] C_SECT   = 8'h30;
  localparam logic [7:0] C_QUERY  = 8'h98;
  localparam logic [7:0] C_RESET  = 8'hF0;
  localparam int         QRY_OFF  = 'h55;

  typedef enum logic [3:0] {
    S_READ, S_UNL1, S_CMD, S_PROG, S_ESET, S_EUNL1, S_ECMD, S_ERASE, S_AUTO, S_QUERY
  } seqState_t;

  typedef enum logic [1:0] {RM_ARRAY, RM_IDENT, RM_QUERY} readMode_t;

  typedef struct packed {
    logic      prog;
    logic      eraseGo;
    logic      eraseAll;
    readMode_t readMode;
  } seqStrobe_t;
endpackage

// File: rtl/nor_seq_ctrl.sv
`timescale 1ns/1ps
module nor_seq_ctrl
  import nor_seq_pkg::*;
#(
  parameter int OFF_W   = 8,
  parameter int UNLOCK0 = 'h55,
  parameter int UNLOCK1 = 'h2A
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [OFF_W-1:0] cmdAddr,
  input  logic [7:0]       cmdByte,
  input  logic             busyIn,
  output seqStrobe_t       strobe
);
  seqState_t state, nxtState;
  logic bypass, nxtBypass, fail;
  logic atU0, atU1, cfiHit;

  assign atU0   = cmdAddr == OFF_W'(UNLOCK0);
  assign atU1   = cmdAddr == OFF_W'(UNLOCK1);
  assign cfiHit = (cmdAddr == OFF_W'(QRY_OFF)) && (cmdByte == C_QUERY);

  always_comb begin
    nxtState        = state;
    nxtBypass       = bypass;
    fail            = 1'b0;
    strobe.prog     = 1'b0;
    strobe.eraseGo  = 1'b0;
    strobe.eraseAll = 1'b0;
    case (state)
      S_AUTO:  strobe.readMode = RM_IDENT;
      S_QUERY: strobe.readMode = RM_QUERY;
      default: strobe.readMode = RM_ARRAY;
    endcase
    if (state == S_ERASE) begin
      if (!busyIn) nxtState = bypass ? S_CMD : S_READ;
    end else if (wrEn) begin
      if (cmdByte == C_RESET && state != S_PROG) begin
        fail = 1'b1;
      end else begin
        case (state)
          S_READ, S_ESET: begin
            if (cfiHit) nxtState = S_QUERY;
            else if (atU0 && cmdByte == C_UNL_A) nxtState = (state == S_READ) ? S_UNL1 : S_EUNL1;
            else fail = 1'b1;
          end
          S_UNL1:  if (atU1 && cmdByte == C_UNL_B) nxtState = S_CMD;  else fail = 1'b1;
          S_EUNL1: if (atU1 && cmdByte == C_UNL_B) nxtState = S_ECMD; else fail = 1'b1;
          S_CMD: begin
            if (!bypass && !atU0) fail = 1'b1;
            else begin
              case (cmdByte)
                C_BYPASS: nxtBypass = 1'b1;
                C_ESETUP: nxtState  = S_ESET;
                C_AUTO:   nxtState  = S_AUTO;
                C_PROG:   nxtState  = S_PROG;
                default:  fail      = 1'b1;
              endcase
            end
          end
          S_PROG: begin
            strobe.prog = 1'b1;
            nxtState    = bypass ? S_CMD : S_READ;
          end
          S_ECMD: begin
            if (cmdByte == C_CHIP && atU0) begin
              strobe.eraseGo  = 1'b1;
              strobe.eraseAll = 1'b1;
              nxtState        = S_ERASE;
            end else if (cmdByte == C_SECT) begin
              strobe.eraseGo = 1'b1;
              nxtState       = S_ERASE;
            end else fail = 1'b1;
          end
          S_AUTO:  if (cfiHit) nxtState = S_QUERY; else fail = 1'b1;
          default: fail = 1'b1;
        endcase
      end
      if (fail) begin
        nxtState  = S_READ;
        nxtBypass = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= S_READ;
      bypass <= 1'b0;
    end else begin
      state  <= nxtState;
      bypass <= nxtBypass;
    end
  end

  p_f0_resets_r4: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && state != S_ERASE && state != S_PROG && cmdByte == C_RESET)
      |=> (state == S_READ && !bypass));

  p_query_exit_r10: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_QUERY && wrEn) |=> (state == S_READ));

  p_bypass_entry_r8: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_CMD && wrEn && cmdByte == C_BYPASS && (bypass || atU0))
      |=> (bypass && state == S_CMD));

  p_prog_needs_write_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.prog |-> (wrEn && $past(state) != S_ERASE));
endmodule

// File: rtl/nor_seq_dpath.sv
`timescale 1ns/1ps
module nor_seq_dpath
  import nor_seq_pkg::*;
#(
  parameter int      DW           = 16,
  parameter int      OFF_W        = 8,
  parameter int      AW           = 10,
  parameter int      SECTORS      = 4,
  parameter int      SECTOR_BYTES = 512,
  parameter int      SIZE_LOG2    = 11,
  parameter logic [DW-1:0] MANUF_ID  = '0,
  parameter logic [DW-1:0] DEVICE_ID = '0,
  parameter logic [DW-1:0] EXT_ID0   = '1,
  parameter logic [DW-1:0] EXT_ID1   = '1,
  parameter int      QRY_LEN      = 'h40
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          rdEn,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wrData,
  input  seqStrobe_t    strobe,
  output logic [DW-1:0] rdData,
  output logic          busy
);
  localparam int NWORDS = 2 ** AW;

  logic [DW-1:0]    mem [NWORDS];
  logic [AW-1:0]    eraseIdx, eraseEnd;
  logic [OFF_W-1:0] off;
  logic [DW-1:0]    arrWord;

  assign off     = addr[OFF_W-1:0];
  assign arrWord = mem[addr];

  function automatic logic [7:0] qryByte(input int o);
    case (o)
      'h10: return 8'h51;
      'h11: return 8'h52;
      'h12: return 8'h59;
      'h13: return 8'h02;
      'h27: return 8'(SIZE_LOG2);
      'h28: return 8'h01;
      'h2C: return 8'h01;
      'h2D: return 8'((SECTORS - 1) & 'hFF);
      'h2E: return 8'(((SECTORS - 1) >> 8) & 'hFF);
      'h2F: return 8'((SECTOR_BYTES >> 8) & 'hFF);
      'h30: return 8'((SECTOR_BYTES >> 16) & 'hFF);
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [DW-1:0] identWord(input int o, input logic [DW-1:0] arr);
    case (o)
      0:     return MANUF_ID;
      1:     return DEVICE_ID;
      2:     return '0;
      'h0E:  return (EXT_ID0 == '1) ? arr : EXT_ID0;
      'h0F:  return (EXT_ID1 == '1) ? arr : EXT_ID1;
      default: return arr;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (busy) mem[eraseIdx] <= '1;
    else if (strobe.prog) mem[addr] <= arrWord & wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy     <= 1'b0;
      eraseIdx <= '0;
      eraseEnd <= '0;
    end else if (strobe.eraseGo) begin
      busy     <= 1'b1;
      eraseIdx <= strobe.eraseAll ? '0 : {addr[AW-1:OFF_W], {OFF_W{1'b0}}};
      eraseEnd <= strobe.eraseAll ? '1 : {addr[AW-1:OFF_W], {OFF_W{1'b1}}};
    end else if (busy) begin
      if (eraseIdx == eraseEnd) busy <= 1'b0;
      else eraseIdx <= eraseIdx + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdData <= '0;
    else if (rdEn) begin
      case (strobe.readMode)
        RM_IDENT: rdData <= identWord(int'(off), arrWord);
        RM_QUERY: rdData <= (int'(off) < QRY_LEN) ? DW'(qryByte(int'(off))) : '0;
        default:  rdData <= arrWord;
      endcase
    end
  end

  p_go_sets_busy_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.eraseGo |=> busy);

  p_fill_ends_r5: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !strobe.eraseGo && eraseIdx == eraseEnd) |=> !busy);

  p_quiet_when_busy_r7: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (!strobe.prog && !strobe.eraseGo));

  p_chip_fill_from_zero_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.eraseGo && strobe.eraseAll) |=> (eraseIdx == '0 && eraseEnd == '1));
endmodule

// File: rtl/nor_cmd_seq.sv
`timescale 1ns/1ps
module nor_cmd_seq
  import nor_seq_pkg::*;
#(
  parameter int WORD_BYTES   = 2,
  parameter int SECTOR_BYTES = 512,
  parameter int SECTORS      = 4,
  parameter int UNLOCK0      = 'h55,
  parameter int UNLOCK1      = 'h2A,
  parameter logic [8*WORD_BYTES-1:0] MANUF_ID  = 16'h0001,
  parameter logic [8*WORD_BYTES-1:0] DEVICE_ID = 16'h227E,
  parameter logic [8*WORD_BYTES-1:0] EXT_ID0   = 16'h2201,
  parameter logic [8*WORD_BYTES-1:0] EXT_ID1   = 16'hFFFF,
  parameter int QRY_LEN = 'h40,
  localparam int DW    = 8 * WORD_BYTES,
  localparam int WPS   = SECTOR_BYTES / WORD_BYTES,
  localparam int OFF_W = $clog2(WPS),
  localparam int SEC_W = (SECTORS > 1) ? $clog2(SECTORS) : 1,
  localparam int AW    = OFF_W + SEC_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          rdEn,
  input  logic          wrEn,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wrData,
  output logic [DW-1:0] rdData,
  output logic          busy
);
  seqStrobe_t strobe;

  nor_seq_ctrl #(.OFF_W(OFF_W), .UNLOCK0(UNLOCK0), .UNLOCK1(UNLOCK1)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .cmdAddr(addr[OFF_W-1:0]),
    .cmdByte(wrData[7:0]), .busyIn(busy), .strobe(strobe)
  );

  nor_seq_dpath #(
    .DW(DW), .OFF_W(OFF_W), .AW(AW), .SECTORS(SECTORS), .SECTOR_BYTES(SECTOR_BYTES),
    .SIZE_LOG2($clog2(SECTORS * SECTOR_BYTES)), .MANUF_ID(MANUF_ID), .DEVICE_ID(DEVICE_ID),
    .EXT_ID0(EXT_ID0), .EXT_ID1(EXT_ID1), .QRY_LEN(QRY_LEN)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .rdEn(rdEn), .addr(addr), .wrData(wrData),
    .strobe(strobe), .rdData(rdData), .busy(busy)
  );
endmodule

// File: tb/sim_nor_cmd_seq.sv
`timescale 1ns/1ps
module sim_nor_cmd_seq;
  localparam logic [9:0] U0 = 10'h055;
  localparam logic [9:0] U1 = 10'h02A;

  logic clk = 1'b0, rstN = 1'b0, rdEn = 1'b0, wrEn = 1'b0;
  logic [9:0]  addr = '0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic        busy;
  logic [15:0] model [1024];
  int checks = 0, errors = 0;
  logic done = 1'b0;

  always #4 clk = ~clk;

  nor_cmd_seq u0 (.clk(clk), .rstN(rstN), .rdEn(rdEn), .wrEn(wrEn), .addr(addr),
                  .wrData(wrData), .rdData(rdData), .busy(busy));

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [9:0] a, input logic [15:0] d);
    @(negedge clk); wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic rd(input logic [9:0] a, output logic [15:0] v);
    @(negedge clk); rdEn = 1'b1; addr = a;
    @(negedge clk); rdEn = 1'b0; v = rdData;
  endtask

  task automatic rdChk(input string tag, input logic [9:0] a, input logic [15:0] exp);
    logic [15:0] v;
    rd(a, v);
    check(tag, v, exp);
  endtask

  task automatic unlock(input logic [1:0] sec);
    wr({sec, U0[7:0]}, 16'h00AA);
    wr({sec, U1[7:0]}, 16'h0055);
  endtask

  task automatic progFull(input logic [9:0] a, input logic [15:0] d);
    unlock(2'd0); wr(U0, 16'h00A0); wr(a, d);
    model[a] = model[a] & d;
  endtask

  task automatic eraseSeq(input logic [9:0] a, input logic [15:0] code);
    unlock(2'd0); wr(U0, 16'h0080); unlock(2'd0); wr(a, code);
  endtask

  task automatic waitErase(output int n);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
    @(negedge clk);
  endtask

  function automatic logic [15:0] andModel(input logic [15:0] o, input logic [15:0] d);
    return o & d;
  endfunction

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    logic [15:0] v;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R1 busy after reset", {15'd0, busy}, 16'h0000);
    check("R1 rdData after reset", rdData, 16'h0000);
    rstN = 1'b1;
    @(negedge clk);

    // R6 chip erase
    eraseSeq(U0, 16'h0010);
    check("R6 busy after chip erase", {15'd0, busy}, 16'h0001);
    waitErase(n);
    check("R6 chip erase busy length", 16'(n), 16'd1024);
    for (int i = 0; i < 1024; i++) model[i] = 16'hFFFF;
    rdChk("R6 first word erased", 10'h000, 16'hFFFF);
    rdChk("R1 R6 last word erased", 10'h3FF, 16'hFFFF);
    eraseSeq(U1, 16'h0010);
    @(negedge clk);
    check("R6 chip erase at wrong offset", {15'd0, busy}, 16'h0000);

    // R2 program AND
    progFull(10'd5, 16'h1234);
    rdChk("R2 program", 10'd5, 16'h1234);
    progFull(10'd5, 16'hFF0F);
    rdChk("R2 AND only", 10'd5, andModel(16'h1234, 16'hFF0F));

    // R3 broken sequences
    wr(U0, 16'h00AA); wr(U0, 16'h0055); wr(U0, 16'h00A0); wr(10'd7, 16'h0000);
    rdChk("R3 bad second offset", 10'd7, 16'hFFFF);
    unlock(2'd0); wr(U0, 16'h0077); wr(10'd8, 16'h0000);
    rdChk("R3 bad command byte", 10'd8, 16'hFFFF);
    unlock(2'd0); wr(U1, 16'h00A0); wr(10'd9, 16'h0000);
    rdChk("R3 command at wrong offset", 10'd9, 16'hFFFF);

    // R11 command offsets in any sector
    wr({2'd3, U0[7:0]}, 16'h00AA); wr({2'd2, U1[7:0]}, 16'h0055);
    wr({2'd1, U0[7:0]}, 16'h00A0); wr(10'h303, 16'h00FF);
    model[10'h303] = 16'h00FF;
    rdChk("R11 unlock in other sectors", 10'h303, 16'h00FF);

    // R4 F0 handling
    unlock(2'd0); wr(U0, 16'h00A0); wr(10'd20, 16'h00F0);
    model[20] = 16'h00F0;
    rdChk("R4 F0 as program data", 10'd20, 16'h00F0);
    wr(U0, 16'h00AA); wr(10'd0, 16'h00F0); wr(U1, 16'h0055); wr(U0, 16'h00A0); wr(10'd21, 16'h0000);
    rdChk("R4 F0 aborts unlock", 10'd21, 16'hFFFF);

    // R8 shortcut mode
    unlock(2'd0); wr(U0, 16'h0020);
    wr(10'd100, 16'h00A0); wr(10'd30, 16'h1111);
    wr(10'd200, 16'h00A0); wr(10'd31, 16'h2222);
    model[30] = 16'h1111; model[31] = 16'h2222;
    rdChk("R8 shortcut program 1", 10'd30, 16'h1111);
    rdChk("R8 shortcut program 2", 10'd31, 16'h2222);
    wr(10'd3, 16'h0090); wr(10'd0, 16'h0000);
    wr(10'd5, 16'h00A0); wr(10'd32, 16'h0000);
    rdChk("R8 exit via ident 0x00", 10'd32, 16'hFFFF);
    unlock(2'd0); wr(U0, 16'h0020); wr(10'd0, 16'h00F0);
    wr(10'd0, 16'h00A0); wr(10'd33, 16'h0000);
    rdChk("R4 R8 F0 leaves shortcut", 10'd33, 16'hFFFF);

    // R9 R12 identification
    progFull(10'h00F, 16'hABCD);
    unlock(2'd0); wr(U0, 16'h0090);
    rdChk("R9 manufacturer", 10'h000, 16'h0001);
    rdChk("R9 device", 10'h001, 16'h227E);
    rdChk("R9 protect word", 10'h002, 16'h0000);
    rdChk("R9 extra id 0", 10'h00E, 16'h2201);
    rdChk("R12 all-ones id reads array", 10'h00F, 16'hABCD);
    rdChk("R9 other offset reads array", 10'h005, model[5]);
    rdChk("R9 R11 device in sector 1", 10'h101, 16'h227E);
    wr(10'd0, 16'h00F0);
    rdChk("R9 back to array", 10'h001, 16'hFFFF);

    // R10 query mode
    wr(U0, 16'h0098);
    rdChk("R10 Q", 10'h010, 16'h0051);
    rdChk("R10 R", 10'h011, 16'h0052);
    rdChk("R10 Y", 10'h012, 16'h0059);
    rdChk("R10 size", 10'h027, 16'h000B);
    rdChk("R10 beyond length", 10'h050, 16'h0000);
    wr(10'd0, 16'h1234);
    rdChk("R10 write exits", 10'h010, 16'hFFFF);
    unlock(2'd0); wr(U0, 16'h0090); wr(U0, 16'h0098);
    rdChk("R10 from ident", 10'h012, 16'h0059);
    wr(10'd0, 16'h00F0);

    // R5 sector erase
    progFull(10'h140, 16'h0000); progFull(10'h240, 16'h0000);
    eraseSeq(10'h1A7, 16'h0030);
    waitErase(n);
    check("R5 sector busy length", 16'(n), 16'd256);
    for (int i = 10'h100; i < 10'h200; i++) model[i] = 16'hFFFF;
    rdChk("R5 erased word", 10'h140, 16'hFFFF);
    rdChk("R5 sector low edge", 10'h100, 16'hFFFF);
    rdChk("R5 sector high edge", 10'h1FF, 16'hFFFF);
    rdChk("R5 other sector kept", 10'h240, 16'h0000);
    rdChk("R5 below sector kept", 10'h0FF, model[10'h0FF]);

    // R7 writes ignored during erase
    eraseSeq(10'h2C3, 16'h0030);
    unlock(2'd0); wr(U0, 16'h00A0); wr(10'h040, 16'h0000); wr(10'd0, 16'h00F0);
    waitErase(n);
    for (int i = 10'h200; i < 10'h300; i++) model[i] = 16'hFFFF;
    rdChk("R7 program ignored during erase", 10'h040, 16'hFFFF);
    rdChk("R7 R5 erase completed", 10'h240, 16'hFFFF);
    progFull(10'h041, 16'h5555);
    rdChk("R7 normal after erase", 10'h041, 16'h5555);

    // random programs and reads
    for (int k = 0; k < 150; k++) begin
      logic [9:0] a;
      logic [15:0] d;
      a = 10'($urandom % 1024);
      d = 16'($urandom);
      progFull(a, d);
      if (($urandom % 3) == 0) begin
        a = 10'($urandom % 1024);
        rdChk("R2 random read", a, model[a]);
      end
    end
    for (int k = 0; k < 40; k++) begin
      logic [9:0] a;
      a = 10'($urandom % 1024);
      rdChk("R1 random array read", a, model[a]);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule